// File: doc/BRIEF.md
# Two-Channel Interleaved Half-Band Decimator

This block halves the sample rate of two signed sample streams, called A and B, that share one input port in strict time interleave. Both streams pass through a single seven-tap half-band low-pass filter built only from registers, adders and fixed shifts, so it uses no hardware multipliers. The decimated results of both streams leave on one output port, still interleaved and carrying the tag of the stream they belong to.

The filter's impulse response is -1/32, 0, 9/32, 1/2, 9/32, 0, -1/32. The delay line is shared by both streams, and each per-stream delay of one sample is stretched to two line positions. A tap therefore only ever sees samples of the stream being computed. The two outer coefficient pairs are applied after their symmetric samples are summed, so the filter needs one constant multiply per pair. Times nine is computed as eight plus one, and the centre tap is a plain shift. The result is rounded back to the input width and clamped to the input range.

Top module: `hbd_decim2`

## Requirements
- R1: While reset is asserted, and after it is released, `out_vld`, `out_ch` and `out_data` are all zero until the first filtered result is produced.
- R2: `in_ch` = 0 tags stream A and `in_ch` = 1 tags stream B. Valid samples alternate A, B, A, B, starting with A after reset. Each result depends only on samples of its own stream, and `out_ch` equals the tag of the sample that produced it.
- R3: Pairs of valid samples (one A, then one B) are numbered from 0 after reset. Only the two samples of even-numbered pairs produce a result. `out_vld` is high for exactly the one clock that follows the accepted sample.
- R4: With x[n] the newest sample of a stream and x[n-k] its k-th predecessor (zero before reset), the unrounded result is (16·x[n-3] + 9·(x[n-2]+x[n-4]) − (x[n]+x[n-6])) / 32.
- R5: Rounding adds one half LSB and then floors, so an exact half rounds toward positive infinity (−0.5 gives 0, +0.5 gives 1, 13.5 gives 14, −13.5 gives −13).
- R6: A rounded result beyond the W-bit signed range is clamped to 2^(W−1)−1 or −2^(W−1).
- R7: A constant input on a stream settles to an output equal to that constant (DC gain of exactly one).
- R8: Clocks with `in_vld` low advance nothing: idle gaps anywhere in the stream leave every result unchanged.
- R9: `out_data` and `out_ch` hold their last values while `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_vld | input | 1 | Input sample strobe |
| in_ch | input | 1 | Stream tag of the input sample (0 = A, 1 = B) |
| in_data | input | W | Signed input sample |
| out_vld | output | 1 | Result strobe, one clock after an accepted even-pair sample |
| out_ch | output | 1 | Stream tag of the result |
| out_data | output | W | Signed, rounded and clamped filter result |

## Verification
The bench aims impulses at one stream while the other stays silent. A design whose delay spacing was one line position instead of two would leak energy into the other stream and put the coefficients at the wrong lags. Exact-half impulses of both signs expose rounding toward zero or a truncating shift, and crafted alternating full-scale sequences drive the accumulator past the output range in both directions, where a missing clamp wraps the sign. Long streams with random gaps and full-range values, compared every clock against a behavioural model, catch a decimation phase that counts clocks instead of pairs, or a line that shifts on idle cycles.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  // Filter shape is fixed: seven taps, coefficients in 1/32 units.
  localparam int unsigned NTAP   = 7;
  localparam int unsigned NCH    = 2;
  localparam int unsigned FRAC   = 5;    // coefficient denominator 2^FRAC
  localparam int unsigned GUARD  = 5;    // headroom bits above the sample width
  localparam logic        TAG_A  = 1'b0;
  localparam logic        TAG_B  = 1'b1;
  // Tap positions (in samples of one stream) used by the half-band form.
  localparam int unsigned T_NEAR = 2;
  localparam int unsigned T_CTR  = 3;
  localparam int unsigned T_FAR  = 4;
  localparam int unsigned T_OLD  = NTAP - 1;
endpackage

// File: rtl/hbd_rst_sync.sv
module hbd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hbd_pair_phase.sv
module hbd_pair_phase
  import hbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  logic in_ch,
  output logic fire
);
  logic pair_q, pair_d;   // 0 = even pair, 1 = odd pair
  logic exp_q, exp_d;     // tag expected on the next valid sample

  always_comb begin
    pair_d = pair_q;
    exp_d  = exp_q;
    if (in_vld) begin
      exp_d = ~exp_q;
      if (in_ch == TAG_B) pair_d = ~pair_q;
    end
    fire = in_vld && !pair_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= 1'b0;
      exp_q  <= TAG_A;
    end else begin
      pair_q <= pair_d;
      exp_q  <= exp_d;
    end
  end

  // R8
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_vld && in_ch == TAG_B) |=> $stable(pair_q));
  // R2
  tag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> (in_ch == exp_q));
endmodule

// File: rtl/hbd_tapline.sv
module hbd_tapline
  import hbd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] t_new,
  output logic [W-1:0] t_near,
  output logic [W-1:0] t_ctr,
  output logic [W-1:0] t_far,
  output logic [W-1:0] t_old
);
  // One stream sample of delay spans NCH line positions.
  localparam int DEPTH = (NTAP - 1) * NCH;

  logic [DEPTH-1:0][W-1:0] line_q, line_d;

  always_comb begin
    line_d = line_q;
    if (in_vld) begin
      line_d[0] = in_data;
      for (int i = 1; i < DEPTH; i++) line_d[i] = line_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  // Tap k of the current stream sits at line position k*NCH-1.
  assign t_new  = in_data;
  assign t_near = line_q[T_NEAR*NCH-1];
  assign t_ctr  = line_q[T_CTR*NCH-1];
  assign t_far  = line_q[T_FAR*NCH-1];
  assign t_old  = line_q[T_OLD*NCH-1];

  // R8
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(line_q));
endmodule

// File: rtl/hbd_shiftadd.sv
module hbd_shiftadd #(
  parameter int W  = 16,
  parameter int AW = 22
) (
  input  logic [W-1:0]         t_new,
  input  logic [W-1:0]         t_near,
  input  logic [W-1:0]         t_ctr,
  input  logic [W-1:0]         t_far,
  input  logic [W-1:0]         t_old,
  output logic signed [AW-1:0] acc
);
  function automatic logic signed [AW-1:0] sx(input logic [W-1:0] v);
    return signed'({{(AW-W){v[W-1]}}, v});
  endfunction

  logic signed [AW-1:0] outer_sum, inner_sum, inner_x9, ctr_x16;

  // Sum the symmetric pairs first, then one constant scale per pair.
  always_comb begin
    outer_sum = sx(t_new) + sx(t_old);
    inner_sum = sx(t_near) + sx(t_far);
    inner_x9  = (inner_sum <<< 3) + inner_sum;
    ctr_x16   = sx(t_ctr) <<< 4;
    acc       = inner_x9 + ctr_x16 - outer_sum;
  end
endmodule

// File: rtl/hbd_round_sat.sv
module hbd_round_sat #(
  parameter int W    = 16,
  parameter int AW   = 22,
  parameter int FRAC = 5
) (
  input  logic signed [AW-1:0] acc,
  output logic [W-1:0]         y
);
  localparam logic signed [AW-1:0] HALF =
    signed'({{(AW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}});
  localparam logic signed [AW-1:0] MAXV =
    signed'({{(AW-W+1){1'b0}}, {(W-1){1'b1}}});
  localparam logic signed [AW-1:0] MINV =
    signed'({{(AW-W+1){1'b1}}, {(W-1){1'b0}}});

  logic signed [AW-1:0] rounded;

  always_comb begin
    rounded = (acc + HALF) >>> FRAC;
    if (rounded > MAXV)      y = MAXV[W-1:0];
    else if (rounded < MINV) y = MINV[W-1:0];
    else                     y = rounded[W-1:0];
  end
endmodule

// File: rtl/hbd_decim2.sv
module hbd_decim2
  import hbd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic         in_ch,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  output logic         out_ch,
  output logic [W-1:0] out_data
);
  localparam int AW = W + GUARD + 1;

  logic          rst_sync_n;
  logic          fire;
  logic [W-1:0]  t_new, t_near, t_ctr, t_far, t_old;
  logic signed [AW-1:0] acc;
  logic [W-1:0]  y;

  logic          vld_q, vld_d;
  logic          ch_q, ch_d;
  logic [W-1:0]  data_q, data_d;

  hbd_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  hbd_pair_phase u_phase (
    .clk(clk), .rst_n(rst_sync_n), .in_vld(in_vld), .in_ch(in_ch), .fire(fire)
  );

  hbd_tapline #(.W(W)) u_line (
    .clk(clk), .rst_n(rst_sync_n), .in_vld(in_vld), .in_data(in_data),
    .t_new(t_new), .t_near(t_near), .t_ctr(t_ctr), .t_far(t_far), .t_old(t_old)
  );

  hbd_shiftadd #(.W(W), .AW(AW)) u_mac (
    .t_new(t_new), .t_near(t_near), .t_ctr(t_ctr), .t_far(t_far), .t_old(t_old),
    .acc(acc)
  );

  hbd_round_sat #(.W(W), .AW(AW), .FRAC(FRAC)) u_rsat (
    .acc(acc), .y(y)
  );

  always_comb begin
    vld_d  = fire;
    ch_d   = ch_q;
    data_d = data_q;
    if (fire) begin
      ch_d   = in_ch;
      data_d = y;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      ch_q   <= TAG_A;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      ch_q   <= ch_d;
      data_q <= data_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_ch   = ch_q;
  assign out_data = data_q;

  // R3
  out_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_vld |-> $past(in_vld));
  // R2
  out_tag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_vld |-> (out_ch == $past(in_ch)));
  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_vld |-> ($stable(out_data) && $stable(out_ch)));
endmodule

// File: tb/hbd_decim2_tb.sv
`timescale 1ns/1ps
module hbd_decim2_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic         in_ch = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_vld;
  logic         out_ch;
  logic [W-1:0] out_data;

  always #10 clk = ~clk;   // 50 MHz

  hbd_decim2 #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ch(in_ch), .in_data(in_data),
    .out_vld(out_vld), .out_ch(out_ch), .out_data(out_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural reference state
  int hist[2][7];
  int pair_cnt;
  bit pend_vld;
  bit pend_ch;
  int pend_data;
  int held_data;
  bit held_ch;
  int last_out[2];
  string cur_req = "R4";
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_out(input int h[7]);
    int acc, r;
    acc = 16*h[3] + 9*(h[2] + h[4]) - (h[0] + h[6]);
    r = (acc + 16) >>> 5;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int sval(input logic [W-1:0] v);
    return int'(signed'(v));
  endfunction

  task automatic compare_outputs();
    chk(out_vld == pend_vld, "R3", int'(out_vld), int'(pend_vld));
    if (pend_vld) begin
      chk(out_ch == pend_ch, "R2", int'(out_ch), int'(pend_ch));
      chk(sval(out_data) == pend_data, cur_req, sval(out_data), pend_data);
      held_data = pend_data;
      held_ch   = pend_ch;
      last_out[pend_ch] = pend_data;
    end else begin
      chk(sval(out_data) == held_data, "R9", sval(out_data), held_data);
      chk(out_ch == held_ch, "R9", int'(out_ch), int'(held_ch));
    end
  endtask

  task automatic cycle(input bit v, input bit c, input int d);
    @(negedge clk);
    compare_outputs();
    in_vld  = v;
    in_ch   = c;
    in_data = d[W-1:0];
    pend_vld = 1'b0;
    if (v) begin
      for (int k = 6; k > 0; k--) hist[c][k] = hist[c][k-1];
      hist[c][0] = sval(d[W-1:0]);
      if (pair_cnt % 2 == 0) begin
        pend_vld  = 1'b1;
        pend_ch   = c;
        pend_data = ref_out(hist[c]);
      end
      if (c) pair_cnt++;
    end
  endtask

  task automatic send_pair(input int a, input int b);
    cycle(1'b1, 1'b0, a);
    cycle(1'b1, 1'b1, b);
  endtask

  task automatic flush();
    cycle(1'b0, 1'b0, 0);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0; in_vld = 1'b0; in_ch = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs idle and zero after reset
    chk(out_vld == 1'b0, "R1", int'(out_vld), 0);
    chk(out_ch == 1'b0, "R1", int'(out_ch), 0);
    chk(out_data == '0, "R1", sval(out_data), 0);
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 7; k++) hist[c][k] = 0;
      last_out[c] = 0;
    end
    pair_cnt = 0; pend_vld = 0; held_data = 0; held_ch = 0;
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 8);
  endfunction

  initial begin
    // R1 during reset
    repeat (2) @(negedge clk);
    chk(out_vld == 1'b0 && out_data == '0, "R1", sval(out_data), 0);

    // R4 / R2: impulse on A only, B silent
    reset_dut();
    cur_req = "R4";
    send_pair(1024, 0); flush();
    chk(last_out[0] == -32, "R4", last_out[0], -32);
    chk(last_out[1] == 0, "R2", last_out[1], 0);
    send_pair(0, 0); send_pair(0, 0); flush();
    chk(last_out[0] == 288, "R4", last_out[0], 288);
    send_pair(0, 0); send_pair(0, 0); flush();
    chk(last_out[0] == 288, "R4", last_out[0], 288);
    send_pair(0, 0); send_pair(0, 0); flush();
    chk(last_out[0] == -32, "R4", last_out[0], -32);
    chk(last_out[1] == 0, "R2", last_out[1], 0);

    // R4 centre tap / R2: impulse on B in odd pair, A silent
    reset_dut();
    send_pair(0, 0); send_pair(0, 2000);
    send_pair(0, 0); send_pair(0, 0); send_pair(0, 0); flush();
    chk(last_out[1] == 1000, "R4", last_out[1], 1000);
    chk(last_out[0] == 0, "R2", last_out[0], 0);

    // R5: exact halves of both signs
    reset_dut();
    cur_req = "R5";
    send_pair(16, -16); flush();
    chk(last_out[0] == 0, "R5", last_out[0], 0);
    chk(last_out[1] == 1, "R5", last_out[1], 1);
    reset_dut();
    send_pair(48, -48); send_pair(0, 0); send_pair(0, 0); flush();
    chk(last_out[0] == 14, "R5", last_out[0], 14);
    chk(last_out[1] == -13, "R5", last_out[1], -13);

    // R6: clamp in both directions
    reset_dut();
    cur_req = "R6";
    send_pair(-32768, 32767); send_pair(0, 0);
    send_pair(32767, -32768); send_pair(32767, -32768); send_pair(32767, -32768);
    send_pair(0, 0); send_pair(-32768, 32767); flush();
    chk(last_out[0] == 32767, "R6", last_out[0], 32767);
    chk(last_out[1] == -32768, "R6", last_out[1], -32768);

    // R7: DC gain, with idle gaps (R8)
    reset_dut();
    cur_req = "R7";
    for (int p = 0; p < 10; p++) begin
      send_pair(5000, -3000);
      if (p % 3 == 1) begin flush(); flush(); end
    end
    flush();
    chk(last_out[0] == 5000, "R7", last_out[0], 5000);
    chk(last_out[1] == -3000, "R7", last_out[1], -3000);

    // R8 / R3: long random stream with gaps, model compared every clock
    reset_dut();
    cur_req = "R8";
    for (int p = 0; p < 600; p++) begin
      int a, b, g;
      a = rnd(); b = rnd(); g = rnd();
      if ((g & 3) == 0) begin a = (a & 1) ? 32767 : -32768; end
      else a = (a % 65536) - 32768;
      b = (b % 65536) - 32768;
      if (b < -32768) b = -32768;
      if (a < -32768) a = -32768;
      cycle(1'b1, 1'b0, a);
      if ((g & 16) != 0) flush();
      cycle(1'b1, 1'b1, b);
      if ((g & 96) == 96) begin flush(); flush(); end
    end
    flush(); flush();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule